// File: doc/BRIEF.md
# Kick-Edge Watchdog with Post-Reset Grace Window

This block guards a processor by watching a single kick line. A change of level in either direction counts as a kick and restarts the interval count. If the interval count reaches its limit before another change arrives, the block raises a one-cycle expiry request toward the reset sequencer. Time is measured in ticks of a slow time base, so the limits are small numbers even when the real intervals last seconds.

After every system reset the first interval is a long grace window, roughly thirty times the normal interval, so that boot code has time to start kicking. The first kick after reset switches the block to the short normal interval. While the sequencer reports that reset is active, the count is held at zero and the grace window is armed again. An enable input stands for the board leaving the kick line unconnected; while it is low the block never requests a reset.

Top module: `wd_watchdog`

## Requirements
- R1: While `rst_n` is low and right after it rises, `expire_o` is 0 and the block is in the grace (startup) window with a zero count.
- R2: A rising edge and a falling edge on `kick_i` each count as a kick; a level held for one clock cycle or longer is seen after two synchroniser stages, and the count is cleared within three clock cycles of the change.
- R3: With no kick since reset was released, `expire_o` pulses in the clock cycle after the `STARTUP_TICKS`-th tick, and not earlier.
- R4: Once a kick has been seen, `expire_o` pulses in the cycle after the `TIMEOUT_TICKS`-th tick that follows the most recent kick; a kick line held steadily high or low therefore times out.
- R5: Ticks that arrive before a kick do not count toward the next expiry.
- R6: `expire_o` is high for exactly one clock cycle; an expiry clears the count and keeps the current window, so a further expiry needs a whole new window of ticks.
- R7: While `enable_i` is 0 the count is held at zero and `expire_o` stays 0 regardless of ticks; the current window (grace or normal) is kept for when `enable_i` returns to 1.
- R8: While `sys_rst_active_i` is 1 the count is held at zero, kicks are ignored, `expire_o` stays 0, and the grace window applies again after it falls.
- R9: Priority within one cycle is reset-active, then disable, then kick, then tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| tick_i | input | 1 | One-cycle time-base pulse, synchronous to `clk` |
| kick_i | input | 1 | Asynchronous kick line; either edge is a kick |
| enable_i | input | 1 | 1 = watchdog active, 0 = kick line treated as unconnected |
| sys_rst_active_i | input | 1 | 1 while the reset sequencer holds the system in reset |
| expire_o | output | 1 | One-cycle request for a system reset |

## Verification
A count that drifts by one tick shows at `expire_o` as a pulse one tick early or late, visible at the end of the first window after the fault. A window flag stuck in the wrong state shows as an expiry after the short interval where the grace window was due, or the reverse, and so surfaces within one grace window of a reset release. A missed kick edge shows as an expiry a full interval after the ignored edge, while a count not held during disable or reset-active shows as a pulse during the held period or too early after it.

// File: rtl/wd_pkg.sv
package wd_pkg;

  // Which window length is currently in force.
  typedef enum logic {
    PH_STARTUP = 1'b0,
    PH_NORMAL  = 1'b1
  } wd_phase_e;

  // Bits needed to hold values 0 .. max_val.
  function automatic int cnt_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/wd_kick_detect.sv
// Brings the asynchronous kick line into the clock domain and flags
// every change of level, in either direction.
module wd_kick_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic kick_edge_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = kick_i;
    end else begin : g_chain
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], kick_i};
    end
  endgenerate

  always_comb prev_d = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign kick_edge_o = sync_q[SYNC_STAGES-1] ^ prev_q;

  // R2: a change in the synchronised level is flagged for exactly the cycle
  // in which it first appears at the last stage.
  p_edge_single_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    kick_edge_o |=> (prev_q == $past(sync_q[SYNC_STAGES-1])));

endmodule

// File: rtl/wd_window_sel.sv
// Chooses the terminal count for the window in force.
module wd_window_sel
  import wd_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 1600,
  parameter int STARTUP_TICKS = 54000,
  parameter int CNT_W         = 16
) (
  input  wd_phase_e        phase_i,
  output logic [CNT_W-1:0] last_o
);

  localparam logic [CNT_W-1:0] NORMAL_LAST  = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [CNT_W-1:0] STARTUP_LAST = CNT_W'(STARTUP_TICKS - 1);

  always_comb begin
    case (phase_i)
      PH_STARTUP: last_o = STARTUP_LAST;
      default:    last_o = NORMAL_LAST;
    endcase
  end

endmodule

// File: rtl/wd_interval_timer.sv
// Tick counter, window flag and expiry pulse.
module wd_interval_timer
  import wd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             enable_i,
  input  logic             kick_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] last_i,
  output wd_phase_e        phase_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  wd_phase_e        ph_q, ph_d;
  logic             exp_q, exp_d;
  logic             cnt_en;
  logic             at_last;

  assign at_last = (cnt_q == last_i);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    exp_d = 1'b0;
    if (hold_i) begin
      cnt_d = '0;
      ph_d  = PH_STARTUP;
    end else if (!enable_i) begin
      cnt_d = '0;
    end else if (kick_i) begin
      cnt_d = '0;
      ph_d  = PH_NORMAL;
    end else if (tick_i) begin
      if (at_last) begin
        cnt_d = '0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  // Counter and flag only move when one of the controls is active.
  assign cnt_en = hold_i | !enable_i | kick_i | tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_STARTUP;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_q <= 1'b0;
    else        exp_q <= exp_d;
  end

  assign phase_o  = ph_q;
  assign expire_o = exp_q;

  // R4: the count never passes the terminal value of the window in force.
  p_cnt_bound_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_i);

  // R6: the request lasts one cycle and leaves the count at zero.
  p_pulse_one_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |=> !exp_q);
  p_expiry_clears_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |-> (cnt_q == '0) && (ph_q == $past(ph_q)));

  // R7: disabled means no request and a zero count, window kept.
  p_disable_quiet_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !hold_i) |=> (!exp_q && cnt_q == '0 && ph_q == $past(ph_q)));

  // R8: reset-active holds the count, re-arms the grace window, blocks requests.
  p_hold_rearm_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!exp_q && cnt_q == '0 && ph_q == PH_STARTUP));

  // R2 / R9: a kick outranks a tick and moves to the normal window.
  p_kick_clears_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && enable_i && !hold_i) |=> (!exp_q && cnt_q == '0 && ph_q == PH_NORMAL));

endmodule

// File: rtl/wd_watchdog.sv
// Watchdog top: kick synchroniser, window selection and interval timer.
module wd_watchdog
  import wd_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 1600,
  parameter int STARTUP_TICKS = 54000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic kick_i,
  input  logic enable_i,
  input  logic sys_rst_active_i,
  output logic expire_o
);

  localparam int MAX_TICKS = (STARTUP_TICKS > TIMEOUT_TICKS) ? STARTUP_TICKS : TIMEOUT_TICKS;
  localparam int CNT_W     = cnt_width(MAX_TICKS);

  initial begin
    if (TIMEOUT_TICKS < 2 || STARTUP_TICKS < 2 || SYNC_STAGES < 1)
      $error("wd_watchdog: window lengths must be at least 2 ticks");
  end

  logic             kick_edge;
  logic [CNT_W-1:0] last_cnt;
  wd_phase_e        phase;

  wd_kick_detect #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_kick (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick_i      (kick_i),
    .kick_edge_o (kick_edge)
  );

  wd_window_sel #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .STARTUP_TICKS (STARTUP_TICKS),
    .CNT_W         (CNT_W)
  ) u_sel (
    .phase_i (phase),
    .last_o  (last_cnt)
  );

  wd_interval_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (sys_rst_active_i),
    .enable_i (enable_i),
    .kick_i   (kick_edge),
    .tick_i   (tick_i),
    .last_i   (last_cnt),
    .phase_o  (phase),
    .expire_o (expire_o)
  );

  // R8: no request may follow a cycle spent with reset active.
  p_no_req_in_reset_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_active_i |=> !expire_o);

  // R1: the grace window is in force straight after power-on reset.
  p_start_window_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (phase == PH_STARTUP && !expire_o));

endmodule

// File: tb/tb_wd_watchdog.sv
`timescale 1ns/1ps
module tb_wd_watchdog;

  localparam int NT = 8;   // normal window, ticks
  localparam int ST = 40;  // grace window, ticks

  logic clk = 1'b0;
  logic rst_n, tick_i, kick_i, enable_i, sys_rst_active_i;
  logic expire_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wd_watchdog #(
    .TIMEOUT_TICKS (NT),
    .STARTUP_TICKS (ST),
    .SYNC_STAGES   (2)
  ) dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .tick_i           (tick_i),
    .kick_i           (kick_i),
    .enable_i         (enable_i),
    .sys_rst_active_i (sys_rst_active_i),
    .expire_o         (expire_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One tick; returns at the negedge after the clock edge that consumed it.
  task automatic one_tick(output logic seen);
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    seen = expire_o;
  endtask

  // n ticks, counting the requests observed after each one.
  task automatic ticks(input int n, output int hits);
    logic s;
    hits = 0;
    for (int i = 0; i < n; i++) begin
      one_tick(s);
      if (s) hits++;
    end
  endtask

  task automatic set_kick(input logic v);
    @(negedge clk) kick_i = v;
    repeat (4) @(negedge clk);
  endtask

  // Expect exactly len ticks to a request, then a one-cycle pulse.
  task automatic expect_window(input int len, input string tag);
    int h;
    logic s;
    ticks(len - 1, h);
    chk(h == 0, {tag, " early request"}, h, 0);
    one_tick(s);
    chk(s == 1'b1, {tag, " request at end of window"}, s, 1);
    @(negedge clk);
    chk(expire_o == 1'b0, "R6 request lasts one cycle", expire_o, 0);
  endtask

  task automatic t_reset_and_grace();
    chk(expire_o == 1'b0, "R1 idle after reset", expire_o, 0);
    // R1 / R3: grace window applies from reset release.
    expect_window(ST, "R3 grace window");
    // R6: count cleared, grace window kept after expiry.
    expect_window(ST, "R6 repeat grace");
  endtask

  task automatic t_rising_kick();
    set_kick(1'b1);                     // R2 rising edge
    expect_window(NT, "R4 normal after rising kick");
    expect_window(NT, "R4 steady high times out");
  endtask

  task automatic t_falling_kick();
    int h;
    ticks(NT - 3, h);
    chk(h == 0, "R5 no request before kick", h, 0);
    set_kick(1'b0);                     // R2 falling edge
    expect_window(NT, "R5 earlier ticks discarded");
  endtask

  task automatic t_short_pulse();
    int h;
    ticks(3, h);
    @(negedge clk) kick_i = 1'b1;       // R2 one-cycle pulse
    @(negedge clk) kick_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(h == 0, "R2 no request before pulse", h, 0);
    expect_window(NT, "R2 one-cycle pulse seen");
  endtask

  task automatic t_disable();
    int h;
    ticks(5, h);
    @(negedge clk) enable_i = 1'b0;
    ticks(ST + NT, h);
    chk(h == 0, "R7 no request while disabled", h, 0);
    @(negedge clk) enable_i = 1'b1;
    expect_window(NT, "R7 count cleared and normal window kept");
  endtask

  task automatic t_reset_hold();
    int h;
    ticks(3, h);
    @(negedge clk) sys_rst_active_i = 1'b1;
    set_kick(1'b1);                     // R8 kicks ignored in reset
    set_kick(1'b0);
    ticks(2 * ST, h);
    chk(h == 0, "R8 no request in reset", h, 0);
    @(negedge clk) sys_rst_active_i = 1'b0;
    // R8 / R9: grace window re-armed although kicks arrived during reset.
    expect_window(ST, "R8 grace re-armed");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tick_i = 1'b0;
    kick_i = 1'b0;
    enable_i = 1'b1;
    sys_rst_active_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(expire_o == 1'b0, "R1 quiet during reset", expire_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_and_grace();
    t_rising_kick();
    t_falling_kick();
    t_short_pulse();
    t_disable();
    t_reset_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule